// File: doc/BRIEF.md
# Frame-Aligned Serial ADC Deserializer

This block turns the serial lanes of a multi-channel converter into parallel sample words. A bit clock runs at half the bit rate and is shared with the data. Every lane is sampled on both of its edges. One frame-clock lane is shared by all channels. It is sampled by the same capture registers as the data, so it is handled as a data lane whose pattern is known.

A low-to-high step in the sampled frame stream marks where a new sample starts. The block works out whether that step lands on the rising-edge bit or on the falling-edge bit of a clock cycle. It locks to that offset and, at each later boundary, moves the shifted-in bits of every channel into an output word with one shared valid strobe.

A build-time parameter selects how each channel's sample is carried:
- One lane per channel carries the whole sample.
- Two lanes per channel each carry half of the sample, so every lane runs at half the serial rate.

A lock tracker ignores a single stray boundary. When two boundaries in a row arrive at the other offset, it moves to that offset and reports the slip.

Top module: `serial_adc_deser`

## Requirements
- R1: Every lane, the frame lane included, is sampled on both edges of `clk`. Within a cycle the bit taken at the rising edge comes before the bit taken at the following falling edge.
- R2: A frame-lane bit of 1 that follows a frame-lane bit of 0 is the first bit of a new sample. The boundary lies at offset 0 when that bit was taken on a rising edge, and at offset 1 when it was taken on a falling edge.
- R3: With LANES=1, lane `laneIn[c]` carries the SAMPLE_W bits of channel c, most significant bit first. The output word is the SAMPLE_W bits that come just before the boundary.
- R4: With LANES=2, lane `laneIn[2c]` carries the lower half of channel c's sample and lane `laneIn[2c+1]` carries the upper half, each most significant bit first.
- R5: Let E be the rising edge at which, or just after which, the first bit of the next sample is taken. The finished word and `wordValid` appear in the cycle that starts at the second rising edge after E.
- R6: `wordValid` is a one-cycle pulse, common to all channels. `sampleWords` changes only together with `wordValid`.
- R7: The first boundary after reset sets the lock offset and produces no word.
- R8: A boundary at the other offset that is followed by a boundary at the locked offset produces no word and no slip. The lock is kept, and the word at the next boundary is correct.
- R9: A second consecutive boundary at the other offset pulses `alignSlip` for one cycle, in the cycle its word would have appeared, with `wordValid` low. The lock moves to the new offset and the following boundaries produce correct words.
- R10: During reset, `wordValid`, `alignSlip` and `sampleWords` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; bits are sampled on both edges |
| rstN | input | 1 | Asynchronous active-low reset |
| frameIn | input | 1 | Frame-clock lane |
| laneIn | input | NUM_CH*LANES | Serial data lanes, LANES per channel |
| sampleWords | output | NUM_CH*SAMPLE_W | Channel c's word at bits c*SAMPLE_W upward |
| wordValid | output | 1 | One-cycle strobe when new words are loaded |
| alignSlip | output | 1 | One-cycle pulse when the lock offset moves |

## Verification
Results are due a fixed number of cycles after the input that causes them. A word and its valid strobe are due two rising edges after the edge that samples, or comes just before, the next sample's first bit. A slip pulse is due in that same cycle.

The bench counts rising edges and half-bit positions. For every frame it records the half-bit index of the first bit of the next sample and computes the cycle in which each strobe must appear. It then compares the cycle and the value of every strobe it observes, sampling at falling edges while the outputs are stable. Acquisition, the single-glitch case and the slip case are covered by counting strobes: a missing or extra strobe is reported as a failure.

// File: rtl/serial_adc_deser_pkg.sv
package serial_adc_deser_pkg;
  // strobes from the frame tracker to the word datapath
  typedef struct packed {
    logic load;    // move assembled words to the outputs
    logic slip;    // lock offset is being moved this cycle
    logic offset;  // locked boundary offset: 0 rising-edge bit, 1 falling-edge bit
  } frm_ctl_t;
endpackage

// File: rtl/sadc_ddr_capture.sv
module sadc_ddr_capture #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] earlyBits,
  output logic [WIDTH-1:0] lateBits
);
  logic [WIDTH-1:0] riseQ;
  logic [WIDTH-1:0] fallQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseQ <= '0;
    else       riseQ <= pins;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallQ <= '0;
    else       fallQ <= pins;
  end

  // falling-edge bits moved back onto the rising edge, paired with their rising partner
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyBits <= '0;
      lateBits  <= '0;
    end else begin
      earlyBits <= riseQ;
      lateBits  <= fallQ;
    end
  end
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
  import serial_adc_deser_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frmEarly,
  input  logic     frmLate,
  output frm_ctl_t ctl,
  output logic     alignSlip
);
  logic prevLate, locked, expOff, missed;
  logic edgeAt0, edgeAt1, seen, seenOff, match, mism;

  always_comb begin
    edgeAt0 = !prevLate && frmEarly;
    edgeAt1 = !frmEarly && frmLate;
    seen    = edgeAt0 || edgeAt1;
    seenOff = edgeAt1;
    match   = locked && seen && (seenOff == expOff);
    mism    = locked && seen && (seenOff != expOff);
    ctl.load   = match;
    ctl.slip   = mism && missed;
    ctl.offset = expOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLate  <= 1'b0;
      locked    <= 1'b0;
      expOff    <= 1'b0;
      missed    <= 1'b0;
      alignSlip <= 1'b0;
    end else begin
      prevLate  <= frmLate;
      alignSlip <= ctl.slip;
      if (seen && !locked) begin
        locked <= 1'b1;
        expOff <= seenOff;
      end
      if (match) missed <= 1'b0;
      if (mism) begin
        if (missed) begin
          expOff <= seenOff;
          missed <= 1'b0;
        end else begin
          missed <= 1'b1;
        end
      end
    end
  end

  // R9
  slip_relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignSlip |-> (expOff != $past(expOff)));
endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import serial_adc_deser_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 14,
  parameter int LANES    = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*LANES-1:0]    dataEarly,
  input  logic [NUM_CH*LANES-1:0]    dataLate,
  input  frm_ctl_t                   ctl,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleWords,
  output logic                       wordValid
);
  localparam int NL  = NUM_CH * LANES;
  localparam int BPL = SAMPLE_W / LANES;

  logic [NUM_CH*SAMPLE_W-1:0] nextWords;

  // lanes are numbered so that lane l holds bits l*BPL upward of the flat word bus
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [BPL-1:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '0;
      else       sh <= {sh[BPL-3:0], dataEarly[l], dataLate[l]};
    end
    assign nextWords[l*BPL +: BPL] = ctl.offset ? {sh[BPL-2:0], dataEarly[l]} : sh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleWords <= '0;
      wordValid   <= 1'b0;
    end else begin
      wordValid <= ctl.load;
      if (ctl.load) sampleWords <= nextWords;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(sampleWords));
endmodule

// File: rtl/serial_adc_deser.sv
module serial_adc_deser
  import serial_adc_deser_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 14,
  parameter int LANES    = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameIn,
  input  logic [NUM_CH*LANES-1:0]    laneIn,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleWords,
  output logic                       wordValid,
  output logic                       alignSlip
);
  localparam int NL = NUM_CH * LANES;

  logic [NL:0] earlyBits, lateBits;
  frm_ctl_t    ctl;

  sadc_ddr_capture #(.WIDTH(NL + 1)) u_cap (
    .clk(clk), .rstN(rstN), .pins({frameIn, laneIn}),
    .earlyBits(earlyBits), .lateBits(lateBits)
  );

  sadc_frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frmEarly(earlyBits[NL]), .frmLate(lateBits[NL]),
    .ctl(ctl), .alignSlip(alignSlip)
  );

  sadc_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .dataEarly(earlyBits[NL-1:0]), .dataLate(lateBits[NL-1:0]),
    .ctl(ctl), .sampleWords(sampleWords), .wordValid(wordValid)
  );

  // R9
  slip_novalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignSlip |-> !wordValid);
endmodule

// File: tb/tb_serial_adc_deser.sv
module tb_serial_adc_deser;
  logic clk = 1'b0;
  logic rstN;
  logic fr1, fr2;
  logic [1:0] dat1;
  logic [3:0] dat2;
  logic [27:0] words1;
  logic [31:0] words2;
  logic valid1, slip1, valid2, slip2;

  always #5 clk = ~clk;

  serial_adc_deser #(.NUM_CH(2), .SAMPLE_W(14), .LANES(1)) dut (
    .clk(clk), .rstN(rstN), .frameIn(fr1), .laneIn(dat1),
    .sampleWords(words1), .wordValid(valid1), .alignSlip(slip1));

  serial_adc_deser #(.NUM_CH(2), .SAMPLE_W(16), .LANES(2)) dutTwo (
    .clk(clk), .rstN(rstN), .frameIn(fr2), .laneIn(dat2),
    .sampleWords(words2), .wordValid(valid2), .alignSlip(slip2));

  // each entry is {channel 1 word, channel 0 word}
  localparam logic [27:0] VEC [8] = '{
    {14'h3FFF, 14'h0000}, {14'h0001, 14'h2000}, {14'h2AAA, 14'h1555},
    {14'h1234, 14'h0ABC}, {14'h0100, 14'h0080}, {14'h3FFE, 14'h0003},
    {14'h0F0F, 14'h30F0}, {14'h1FFF, 14'h2001}};

  int nChecks = 0, nFail = 0;
  int g = 0, cyc = 0;
  logic [27:0] expW1 [32];
  int expC1 [32];
  int n1 = 0, got1 = 0, slipCnt1 = 0, expSlip1 = -1;
  logic [31:0] expW2 [32];
  int expC2 [32];
  int n2 = 0, got2 = 0, slipCnt2 = 0;
  logic [27:0] prev1;
  logic [31:0] prev2;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (valid1) begin
      if (got1 < n1) begin
        chk(words1 == expW1[got1], "R3 one-lane word", words1, expW1[got1]);
        chk(cyc == expC1[got1], "R5 one-lane latency", cyc, expC1[got1]);
      end else chk(1'b0, "R7 unexpected one-lane word", got1, n1);
      got1++;
    end
    if (slip1) begin
      slipCnt1++;
      chk(cyc == expSlip1, "R9 slip cycle", cyc, expSlip1);
    end
    if (valid2) begin
      if (got2 < n2) begin
        chk(words2 == expW2[got2], "R4 two-lane word", words2, expW2[got2]);
        chk(cyc == expC2[got2], "R5 two-lane latency", cyc, expC2[got2]);
      end else chk(1'b0, "R4 unexpected two-lane word", got2, n2);
      got2++;
    end
    if (slip2) slipCnt2++;
  end

  task automatic step();
    #5;
    g++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      fr1 = 0; dat1 = '0; fr2 = 0; dat2 = '0;
      step();
    end
  endtask

  // R1 R2: one 14-bit frame per channel; lateEdge delays the frame step by one bit
  task automatic frame1(input logic [13:0] a, input logic [13:0] b, input bit lateEdge, input bit expPrev);
    int gEdge;
    gEdge = lateEdge ? g + 1 : g;
    if (expPrev) begin
      expW1[n1] = prev1;
      expC1[n1] = gEdge / 2 + 3;
      n1++;
    end
    for (int i = 0; i < 14; i++) begin
      fr1 = lateEdge ? (i >= 1 && i <= 7) : (i < 7);
      dat1[0] = a[13-i];
      dat1[1] = b[13-i];
      step();
    end
    prev1 = {b, a};
  endtask

  // R4: lower byte on the even lane, upper byte on the odd lane
  task automatic frame2(input logic [15:0] a, input logic [15:0] b, input bit expPrev);
    if (expPrev) begin
      expW2[n2] = prev2;
      expC2[n2] = g / 2 + 3;
      n2++;
    end
    for (int i = 0; i < 8; i++) begin
      fr2 = (i < 4);
      dat2[0] = a[7-i];
      dat2[1] = a[15-i];
      dat2[2] = b[7-i];
      dat2[3] = b[15-i];
      step();
    end
    prev2 = {b, a};
  endtask

  initial begin
    rstN = 0; fr1 = 0; fr2 = 0; dat1 = '0; dat2 = '0;
    #2;
    idle(3);
    // R10
    chk(valid1 == 0, "R10 valid in reset", valid1, 0);
    chk(slip1 == 0, "R10 slip in reset", slip1, 0);
    chk(words1 == 0, "R10 words in reset", words1, 0);
    chk(valid2 == 0 && words2 == 0, "R10 two-lane outputs in reset", words2, 0);
    rstN = 1;
    idle(3);
    if (g % 2 != 0) idle(1);
    // R7: the first frame only acquires
    for (int i = 0; i < 8; i++) frame1(VEC[i][13:0], VEC[i][27:14], 1'b0, i != 0);
    // R8: one stray boundary, then back on the locked offset
    frame1(14'h1357, 14'h2468, 1'b1, 1'b0);
    frame1(14'h0F0F, 14'h30C3, 1'b0, 1'b1);
    // R9: permanent one-bit shift of every lane
    idle(1);
    frame1(14'h0111, 14'h0222, 1'b0, 1'b0);
    expSlip1 = g / 2 + 3;
    frame1(14'h3C3C, 14'h03C3, 1'b0, 1'b0);
    frame1(14'h2DB6, 14'h1249, 1'b0, 1'b1);
    frame1(14'h0004, 14'h3FFB, 1'b0, 1'b1);
    frame1(14'h0000, 14'h0000, 1'b0, 1'b1);
    idle(12);
    chk(got1 == n1, "R7 one-lane word count", got1, n1);
    chk(slipCnt1 == 1, "R8 R9 slip count", slipCnt1, 1);
    // R4 with the boundary on a falling-edge bit
    if (g % 2 == 0) idle(1);
    frame2(16'h00FF, 16'hFF00, 1'b0);
    frame2(16'hA55A, 16'h8001, 1'b1);
    frame2(16'h1234, 16'hFEDC, 1'b1);
    for (int i = 0; i < 3; i++) frame2(16'h0001 << (i * 5), 16'h8000 >> (i * 3), 1'b1);
    frame2(16'h0000, 16'h0000, 1'b1);
    idle(10);
    chk(got2 == n2, "R4 two-lane word count", got2, n2);
    chk(slipCnt2 == 0, "R8 no two-lane slip", slipCnt2, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule